// File: doc/BRIEF.md
# LIN Bus Wake-Up Detector

This block watches the LIN receiver output while the transceiver sits in one of its two low-power modes. It decides whether a remote node has asked the bus to wake. While the device is in stop or sleep mode the transmit path is kept off. The detector waits for the bus to stay dominant (low) for at least a programmable number of clock cycles, followed by a return to recessive (high).

A qualified wake-up has a different effect in each mode. In stop mode it raises a one-cycle wake interrupt. In sleep mode it raises a one-cycle system reset request. Either way, a sticky wake flag is set, and software clears it by reading the interrupt status.

The receive-only setting is sampled when a low-power mode is entered. If it is set at that moment, wake-up detection stays off until the device returns to run mode. A bus that is already dominant when a low-power mode is entered does not count: the bus must first be seen recessive.

Top module: `lin_wake_top`

## Requirements
- R1: `txEnable` is 1 only in run mode (`pwrMode` = 2'b00) with `rxOnly` = 0. It is 0 in stop mode (2'b01), in sleep mode (2'b1x), and in run mode with `rxOnly` = 1.
- R2: In stop mode, with detection armed, suppose `linRx` is sampled 0 on at least `MIN_DOM_CYCLES` consecutive rising clock edges and then sampled 1. Then `wakeIrq` is 1 for exactly one cycle, registered on the edge that samples the 1.
- R3: The same qualified pulse in sleep mode gives a one-cycle `resetReq` at that same edge instead of `wakeIrq`.
- R4: A dominant pulse that is sampled on fewer than `MIN_DOM_CYCLES` edges produces no `wakeIrq`, no `resetReq` and no change of `wakeFlag`.
- R5: `wakeFlag` becomes 1 on the same edge as any wake pulse and holds there. A `statusRead` strobe clears it on the next edge. If a wake and a read land on the same edge, the flag stays 1.
- R6: If `rxOnly` is 1 on the cycle a low-power mode is entered from run mode, no wake is produced for the whole stay in that low-power mode, even if `rxOnly` later drops.
- R7: `rxdOut` equals `linRx` in run mode and in stop mode with `rxOnly` = 1. Otherwise it is held at 1 (recessive).
- R8: If the bus is dominant when a low-power mode is entered, that dominant period never produces a wake. Detection starts only after `linRx` has been sampled 1 in the low-power mode.
- R9: In run mode no dominant pulse produces `wakeIrq` or `resetReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrMode | input | 2 | 00 run, 01 stop, 1x sleep |
| rxOnly | input | 1 | Receive-only setting |
| linRx | input | 1 | Receiver output, synchronous; 0 dominant, 1 recessive |
| statusRead | input | 1 | One-cycle strobe: interrupt status is being read |
| txEnable | output | 1 | Transmit driver enable |
| rxdOut | output | 1 | Receive data presented to the host |
| wakeIrq | output | 1 | One-cycle wake interrupt (stop mode) |
| resetReq | output | 1 | One-cycle system reset request (sleep mode) |
| wakeFlag | output | 1 | Sticky wake status bit |

## Verification
The assertions assume that `linRx` is already synchronous to `clk`, so that a release from dominant is sampled exactly once as a rising transition. They also assume that `statusRead` is a single-cycle strobe. The stimulus changes every input only on the falling clock edge and never glitches `linRx` within a cycle. Mode changes go through run mode between stop and sleep, matching the way entry and the latched receive-only setting are defined.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  typedef enum logic [1:0] {
    MODE_RUN       = 2'b00,
    MODE_STOP      = 2'b01,
    MODE_SLEEP     = 2'b10,
    MODE_SLEEP_ALT = 2'b11
  } pwrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic fireIrq;
    logic fireRst;
  } wakeStrobe_t;

endpackage

// File: rtl/lin_wake_ctrl.sv
module lin_wake_ctrl
  import lin_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  pwrMode,
  input  logic        rxOnly,
  input  logic        linRx,
  input  logic        busPrev,
  input  logic        domFull,
  output wakeStrobe_t strobe,
  output logic        txEnable,
  output logic        rxdOut
);

  logic lowPwr, isStop, isSleep, entry, detectOn, rise;
  logic runQ, armedQ, blockQ;

  assign lowPwr  = (pwrMode != MODE_RUN);
  assign isStop  = (pwrMode == MODE_STOP);
  assign isSleep = pwrMode[1];
  assign entry   = lowPwr && runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b1;
      armedQ <= 1'b0;
      blockQ <= 1'b0;
    end else begin
      runQ <= !lowPwr;
      // arming needs a recessive sample inside the low-power stay
      if (!lowPwr)    armedQ <= 1'b0;
      else if (linRx) armedQ <= 1'b1;
      // receive-only is captured once, on entry
      if (!lowPwr)    blockQ <= 1'b0;
      else if (entry) blockQ <= rxOnly;
    end
  end

  assign detectOn = lowPwr && armedQ && !blockQ;
  assign rise     = linRx && !busPrev;

  always_comb begin
    strobe.cntClear = !detectOn || linRx;
    strobe.cntInc   = detectOn && !linRx;
    strobe.fireIrq  = detectOn && rise && domFull && isStop;
    strobe.fireRst  = detectOn && rise && domFull && isSleep;
  end

  assign txEnable = !lowPwr && !rxOnly;
  assign rxdOut   = (!lowPwr || (isStop && rxOnly)) ? linRx : 1'b1;

endmodule

// File: rtl/lin_wake_dp.sv
module lin_wake_dp
  import lin_wake_pkg::*;
#(
  parameter int MIN_DOM_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        linRx,
  input  logic        statusRead,
  input  wakeStrobe_t strobe,
  output logic        busPrev,
  output logic        domFull,
  output logic        wakeIrq,
  output logic        resetReq,
  output logic        wakeFlag
);

  localparam int CNT_W = $clog2(MIN_DOM_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_DOM_CYCLES);

  logic [CNT_W-1:0] domCnt;
  logic             anyWake;

  assign domFull = (domCnt == CNT_MAX);
  assign anyWake = strobe.fireIrq || strobe.fireRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPrev  <= 1'b1;
      domCnt   <= '0;
      wakeIrq  <= 1'b0;
      resetReq <= 1'b0;
      wakeFlag <= 1'b0;
    end else begin
      busPrev <= linRx;
      if (strobe.cntClear)            domCnt <= '0;
      else if (strobe.cntInc && !domFull) domCnt <= domCnt + 1'b1;
      wakeIrq  <= strobe.fireIrq;
      resetReq <= strobe.fireRst;
      if (anyWake)         wakeFlag <= 1'b1;
      else if (statusRead) wakeFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/lin_wake_top.sv
module lin_wake_top
  import lin_wake_pkg::*;
#(
  parameter int MIN_DOM_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwrMode,
  input  logic       rxOnly,
  input  logic       linRx,
  input  logic       statusRead,
  output logic       txEnable,
  output logic       rxdOut,
  output logic       wakeIrq,
  output logic       resetReq,
  output logic       wakeFlag
);

  wakeStrobe_t strobe;
  logic        busPrev, domFull;

  lin_wake_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .rxOnly(rxOnly),
    .linRx(linRx), .busPrev(busPrev), .domFull(domFull),
    .strobe(strobe), .txEnable(txEnable), .rxdOut(rxdOut)
  );

  lin_wake_dp #(.MIN_DOM_CYCLES(MIN_DOM_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .linRx(linRx), .statusRead(statusRead),
    .strobe(strobe), .busPrev(busPrev), .domFull(domFull),
    .wakeIrq(wakeIrq), .resetReq(resetReq), .wakeFlag(wakeFlag)
  );

endmodule

// File: rtl/lin_wake_chk.sv
module lin_wake_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwrMode,
  input logic       linRx,
  input logic       txEnable,
  input logic       wakeIrq,
  input logic       resetReq,
  input logic       wakeFlag
);

  AST_TX_OFF_LOWPWR: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode != 2'b00) |-> !txEnable);                                   // R1
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |=> !wakeIrq);                                               // R2
  AST_IRQ_STOP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> ($past(pwrMode) == 2'b01));                              // R2
  AST_WAKE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq || resetReq) |-> ($past(linRx) && !$past(linRx, 2)));       // R2
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);                                             // R3
  AST_RST_SLEEP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(pwrMode[1]));                                     // R3
  AST_FLAG_WITH_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq || resetReq) |-> wakeFlag);                                 // R5
  AST_NO_RUN_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq || resetReq) |-> ($past(pwrMode) != 2'b00));                // R9

endmodule

bind lin_wake_top lin_wake_chk u_chk (
  .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .linRx(linRx),
  .txEnable(txEnable), .wakeIrq(wakeIrq), .resetReq(resetReq),
  .wakeFlag(wakeFlag)
);

// File: tb/sim_lin_wake_top.sv
`timescale 1ns/1ps
module sim_lin_wake_top;

  localparam int MIN = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwrMode = 2'b00;
  logic       rxOnly = 1'b0;
  logic       linRx = 1'b1;
  logic       statusRead = 1'b0;
  logic       txEnable, rxdOut, wakeIrq, resetReq, wakeFlag;

  typedef struct { bit isRst; int cyc; string req; } expItem_t;
  expItem_t expQ[$];

  int cyc = 0;
  int checks = 0, fails = 0, monChecks = 0, monFails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_wake_top #(.MIN_DOM_CYCLES(MIN)) u0 (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .rxOnly(rxOnly),
    .linRx(linRx), .statusRead(statusRead), .txEnable(txEnable),
    .rxdOut(rxdOut), .wakeIrq(wakeIrq), .resetReq(resetReq),
    .wakeFlag(wakeFlag)
  );

  // monitor: pop expected wake events as they appear
  always @(negedge clk) begin
    if (rstN && (wakeIrq || resetReq)) begin
      monChecks++;
      if (expQ.size() == 0) begin
        monFails++;
        $display("FAIL unexpected wake irq=%0b rst=%0b at cycle %0d (expected none)",
                 wakeIrq, resetReq, cyc);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (wakeIrq !== !e.isRst || resetReq !== e.isRst || cyc != e.cyc) begin
          monFails++;
          $display("FAIL %s wake irq=%0b rst=%0b cyc=%0d expected irq=%0b rst=%0b cyc=%0d",
                   e.req, wakeIrq, resetReq, cyc, !e.isRst, e.isRst, e.cyc);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: dominant pulse of n sampled cycles, then release
  task automatic pulse(int n, bit expWake, bit isRst, string req);
    linRx = 1'b0;
    tick(n);
    linRx = 1'b1;
    if (expWake) expQ.push_back('{isRst, cyc + 1, req});
    tick(3);
  endtask

  task automatic enterMode(logic [1:0] m);
    pwrMode = 2'b00;
    tick(2);
    pwrMode = m;
    tick(2);
  endtask

  task automatic runTests();
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R5 reset flag", wakeFlag, 0);
    chk("R2 reset irq", wakeIrq, 0);
    chk("R3 reset rst", resetReq, 0);
    chk("R1 run tx on", txEnable, 1);

    // run mode: no wake, rxd follows bus
    linRx = 1'b0;
    tick(1);
    chk("R7 run rxd follows", rxdOut, 0);
    tick(MIN + 4);
    linRx = 1'b1;
    tick(3);
    chk("R9 run no wake flag", wakeFlag, 0);

    // stop mode
    enterMode(2'b01);
    chk("R1 stop tx off", txEnable, 0);
    linRx = 1'b0;
    tick(1);
    chk("R7 stop rxd recessive", rxdOut, 1);
    linRx = 1'b1;
    tick(2);
    pulse(MIN - 1, 0, 0, "R4");
    chk("R4 short pulse flag", wakeFlag, 0);
    pulse(MIN, 1, 0, "R2");
    chk("R5 flag after stop wake", wakeFlag, 1);
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
    chk("R5 flag cleared by read", wakeFlag, 0);
    pulse(MIN + 9, 1, 0, "R2");

    // sleep mode
    enterMode(2'b10);
    chk("R1 sleep tx off", txEnable, 0);
    linRx = 1'b0;
    tick(1);
    chk("R7 sleep rxd recessive", rxdOut, 1);
    linRx = 1'b1;
    tick(2);
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
    pulse(MIN + 3, 1, 1, "R3");
    chk("R5 flag after sleep wake", wakeFlag, 1);

    // read on the same edge as a wake: flag stays set
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
    chk("R5 cleared before race", wakeFlag, 0);
    linRx = 1'b0;
    tick(MIN);
    linRx = 1'b1;
    statusRead = 1'b1;
    expQ.push_back('{1'b1, cyc + 1, "R5"});
    tick(1);
    statusRead = 1'b0;
    chk("R5 set wins over read", wakeFlag, 1);
    tick(2);

    // dominant already present on entry
    pwrMode = 2'b00;
    tick(2);
    linRx = 1'b0;
    tick(2);
    pwrMode = 2'b01;
    tick(MIN + 10);
    linRx = 1'b1;
    tick(3);
    chk("R8 stuck dominant no wake", wakeFlag, 1);
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
    chk("R8 flag clear", wakeFlag, 0);
    pulse(MIN, 1, 0, "R8");

    // receive-only latched at entry
    pwrMode = 2'b00;
    rxOnly = 1'b1;
    tick(1);
    chk("R1 run rxonly tx off", txEnable, 0);
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
    pwrMode = 2'b01;
    tick(2);
    linRx = 1'b0;
    tick(1);
    chk("R7 stop rxonly rxd follows", rxdOut, 0);
    tick(MIN + 5);
    linRx = 1'b1;
    tick(3);
    chk("R6 rxonly no wake", wakeFlag, 0);
    rxOnly = 1'b0;
    tick(1);
    pulse(MIN + 5, 0, 0, "R6");
    chk("R6 still blocked after drop", wakeFlag, 0);
    tick(4);
    chk("R2 all expected events seen", expQ.size(), 0);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks + monChecks, fails + monFails);
    $finish;
  end

endmodule